// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, qualifies them against a mask and a record of the levels already being serviced, and raises a single interrupt output to a processor. A processor programs it through a two-address byte interface (`addr`, `wrEn`, `rdEn`, `wrData`, `rdData`). A short start-up sequence of command bytes sets the vector base, the trigger mode and the end-of-service style. After that sequence, command bytes written to the even address retire serviced levels, change the priority order, select which register a read returns, issue a poll and switch special mask mode.

When the processor pulses `intAck`, the block presents `ackVector` in the same cycle. The vector is the programmed base with the winning level in its low three bits. At the following edge the block moves that level from pending to in-service. Priority is fixed by default, with level 0 highest. It can be rotated explicitly, or on each end-of-interrupt, or on each automatic retirement, so that the level just served drops to the bottom. The block runs stand-alone and has no cascade support.

Top module: `prio_int_ctrl`

## Requirements
- R1: After reset `intOut` is low, the mask reads 0x00 on the odd address, an even-address read returns the pending register (0x00), and the priority order is level 0 highest through level 7 lowest.
- R2: An even-address write with bit 4 set restarts the start-up sequence. It clears the mask, in-service and pending registers. Its bit 0 requests a mode byte and its bit 3 selects level triggering (1) or edge triggering (0).
- R3: The first odd-address write after a restart sets the vector base from bits 7:3. An acknowledged level L returns the vector {base[7:3], L}.
- R4: A mode byte is taken as the next odd-address write only when the restart asked for one. Its bit 1 selects automatic retirement, in which the in-service bit is not set at acknowledge. Without a mode byte, automatic retirement is off and the next odd write loads the mask.
- R5: Once start-up is complete, odd-address writes load the mask and odd-address reads return it. A set mask bit keeps that line from raising `intOut`.
- R6: In edge mode a rising input sets its pending bit, and an acknowledge clears it. In level mode the pending bit follows the input one cycle later.
- R7: `intOut` is high only while an unmasked pending level outranks every in-service level. An `intAck` pulse returns the vector of the highest such level and marks it in service.
- R8: Even-address command byte with bits 4:3 = 00 and bits 7:5 = 001 retires the highest-priority in-service level. Bits 7:5 = 011 retire the level given in bits 2:0, so 0x60+L retires level L.
- R9: In the same command byte, code 101 retires the highest in-service level and makes it lowest priority. Code 111 does the same for the level in bits 2:0. Code 110 makes the level in bits 2:0 lowest priority without retiring anything.
- R10: In the same command byte, code 100 turns on rotation under automatic retirement and code 000 turns it off. While it is on, each acknowledged level becomes lowest priority.
- R11: An even-address command byte with bits 4:3 = 01 and bits 1:0 = 10 makes even reads return the pending register. Bits 1:0 = 11 make them return the in-service register.
- R12: Bit 2 set in that byte makes the next even read a poll. The read returns 0x80 plus the level that would interrupt, or 0x00 when none would, and acknowledges that level like `intAck`.
- R13: In that byte, bits 6:5 = 11 enter special mask mode and 10 leave it. In special mask mode, in-service levels whose mask bit is set do not hold off lower levels.
- R14: An `intAck` when no level qualifies returns {base[7:3], 3'b111} and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register address select (0 even, 1 odd) |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle `rdEn` is high |
| irqIn | input | 8 | Interrupt request lines, one per level |
| intOut | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Acknowledge pulse, one cycle |
| ackVector | output | 8 | Vector returned in the acknowledge cycle |

## Verification
The bench builds the block with its package defaults: eight levels on an 8-bit bus, so every 3-bit level code and every wrap of the rotating priority is reachable. With that width, a rotation scenario can place the lowest priority in the middle of the range. It can then check that lines on both sides of the wrap are ranked correctly, and that retired levels move to the bottom. Separate scenarios restart the block in both edge and level mode, with and without a mode byte. These reach the automatic-retirement path, the rotate-on-acknowledge path and the case where the mode byte is skipped.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LVL = 8;
  localparam int LVL_W = $clog2(NUM_LVL);
  localparam int DATA_W = 8;
  localparam int BASE_W = DATA_W - LVL_W;

  typedef enum logic [1:0] {ST_READY, ST_WBASE, ST_WMODE} initSt_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic restart;
    logic loadImr;
    logic eoiHigh;
    logic eoiLvl;
    logic rotEoi;
    logic setLow;
    logic ack;
    logic [LVL_W-1:0] lvl;
    logic [DATA_W-1:0] data;
  } picCmd_t;

  typedef struct packed {
    logic levelMode;
    logic autoEoi;
    logic rotAeoi;
    logic specMask;
  } picCfg_t;
endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  picCmd_t            cmd,
  input  picCfg_t            cfg,
  input  logic [NUM_LVL-1:0] irqIn,
  output logic [NUM_LVL-1:0] irrQ,
  output logic [NUM_LVL-1:0] isrQ,
  output logic [NUM_LVL-1:0] imrQ,
  output logic               intReq,
  output logic [LVL_W-1:0]   ackLvl
);
  localparam logic [LVL_W-1:0] LOW_RESET = LVL_W'(NUM_LVL - 1);

  logic [NUM_LVL-1:0] irqPrev;
  logic [LVL_W-1:0]   prioLow;

  // highest-ranked set bit, scanning from the level after prioLow
  function automatic logic [LVL_W-1:0] topLvl(input logic [NUM_LVL-1:0] bits,
                                              input logic [LVL_W-1:0] low);
    logic [LVL_W-1:0] idx;
    topLvl = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      idx = low + LVL_W'(i + 1);
      if (bits[idx]) topLvl = idx;
    end
  endfunction

  function automatic logic [LVL_W-1:0] rankOf(input logic [LVL_W-1:0] lvl,
                                              input logic [LVL_W-1:0] low);
    rankOf = lvl - low - 1'b1;
  endfunction

  logic [NUM_LVL-1:0] cand, blk, ackMask, riseBits;
  logic [LVL_W-1:0]   blkLvl, eoiSel;
  logic               doAck, eoiHit;

  always_comb begin
    cand     = irrQ & ~imrQ;
    blk      = cfg.specMask ? (isrQ & ~imrQ) : isrQ;
    ackLvl   = topLvl(cand, prioLow);
    blkLvl   = topLvl(blk, prioLow);
    intReq   = (|cand) && (!(|blk) || (rankOf(ackLvl, prioLow) < rankOf(blkLvl, prioLow)));
    doAck    = cmd.ack && intReq;
    ackMask  = doAck ? (NUM_LVL'(1) << ackLvl) : '0;
    eoiSel   = cmd.eoiHigh ? topLvl(isrQ, prioLow) : cmd.lvl;
    eoiHit   = cmd.eoiLvl || (cmd.eoiHigh && (|isrQ));
    riseBits = irqIn & ~irqPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ    <= '0;
      isrQ    <= '0;
      imrQ    <= '0;
      irqPrev <= '0;
      prioLow <= LOW_RESET;
    end else begin
      irqPrev <= irqIn;
      if (cmd.restart) begin
        irrQ    <= '0;
        isrQ    <= '0;
        imrQ    <= '0;
        prioLow <= LOW_RESET;
      end else begin
        if (cmd.loadImr) imrQ <= cmd.data;
        if (cfg.levelMode) irrQ <= irqIn;
        else               irrQ <= (irrQ & ~ackMask) | riseBits;
        begin
          logic [NUM_LVL-1:0] isrNext;
          isrNext = isrQ;
          if (eoiHit) isrNext[eoiSel] = 1'b0;
          if (!cfg.autoEoi) isrNext = isrNext | ackMask;
          isrQ <= isrNext;
        end
        if (cmd.setLow)                            prioLow <= cmd.lvl;
        else if (cmd.rotEoi && eoiHit)             prioLow <= eoiSel;
        else if (doAck && cfg.autoEoi && cfg.rotAeoi) prioLow <= ackLvl;
      end
    end
  end
endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               intAck,
  input  logic [NUM_LVL-1:0] irrQ,
  input  logic [NUM_LVL-1:0] isrQ,
  input  logic [NUM_LVL-1:0] imrQ,
  input  logic               intReq,
  input  logic [LVL_W-1:0]   ackLvl,
  output picCmd_t            cmd,
  output picCfg_t            cfg,
  output logic [BASE_W-1:0]  vecBase,
  output logic               initDone,
  output logic [DATA_W-1:0]  rdData
);
  initSt_t st;
  logic needMode, readIsr, pollPend;
  logic icw1, oddWr, ocw2, ocw3, pollRd;
  logic [2:0] code;

  always_comb begin
    initDone = (st == ST_READY);
    code     = wrData[7:5];
    icw1     = wrEn && !addr && wrData[4];
    oddWr    = wrEn && addr;
    ocw2     = wrEn && !addr && initDone && (wrData[4:3] == 2'b00);
    ocw3     = wrEn && !addr && initDone && (wrData[4:3] == 2'b01);
    pollRd   = rdEn && !addr && pollPend;

    cmd         = '0;
    cmd.restart = icw1;
    cmd.loadImr = oddWr && initDone;
    cmd.eoiHigh = ocw2 && (code == 3'b001 || code == 3'b101);
    cmd.eoiLvl  = ocw2 && (code == 3'b011 || code == 3'b111);
    cmd.rotEoi  = ocw2 && code[2] && code[0];
    cmd.setLow  = ocw2 && (code == 3'b110);
    cmd.ack     = intAck || pollRd;
    cmd.lvl     = wrData[LVL_W-1:0];
    cmd.data    = wrData;

    rdData = '0;
    if (rdEn) begin
      if (addr)          rdData = imrQ;
      else if (pollPend) rdData = intReq ? {1'b1, {(DATA_W-LVL_W-1){1'b0}}, ackLvl} : '0;
      else if (readIsr)  rdData = isrQ;
      else               rdData = irrQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_READY;
      needMode <= 1'b0;
      readIsr  <= 1'b0;
      pollPend <= 1'b0;
      vecBase  <= '0;
      cfg      <= '0;
    end else if (icw1) begin
      st           <= ST_WBASE;
      needMode     <= wrData[0];
      cfg          <= '0;
      cfg.levelMode <= wrData[3];
      readIsr      <= 1'b0;
      pollPend     <= 1'b0;
    end else begin
      if (oddWr && st == ST_WBASE) begin
        vecBase <= wrData[DATA_W-1:LVL_W];
        st      <= needMode ? ST_WMODE : ST_READY;
      end
      if (oddWr && st == ST_WMODE) begin
        cfg.autoEoi <= wrData[1];
        st          <= ST_READY;
      end
      if (ocw2 && code == 3'b100) cfg.rotAeoi <= 1'b1;
      if (ocw2 && code == 3'b000) cfg.rotAeoi <= 1'b0;
      if (pollRd) pollPend <= 1'b0;
      if (ocw3) begin
        if (wrData[1]) readIsr <= wrData[0];
        if (wrData[6]) cfg.specMask <= wrData[5];
        pollPend <= wrData[2];
      end
    end
  end
endmodule

// File: rtl/prio_int_ctrl.sv
module prio_int_ctrl
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_LVL-1:0] irqIn,
  output logic               intOut,
  input  logic               intAck,
  output logic [DATA_W-1:0]  ackVector
);
  picCmd_t            cmd;
  picCfg_t            cfg;
  logic [NUM_LVL-1:0] irrQ, isrQ, imrQ;
  logic [LVL_W-1:0]   ackLvl;
  logic [BASE_W-1:0]  vecBase;
  logic               initDone;

  pic_control u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .intAck(intAck), .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ),
    .intReq(intOut), .ackLvl(ackLvl), .cmd(cmd), .cfg(cfg),
    .vecBase(vecBase), .initDone(initDone), .rdData(rdData)
  );

  pic_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfg(cfg), .irqIn(irqIn),
    .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ), .intReq(intOut), .ackLvl(ackLvl)
  );

  // no qualifying level: vector carries the lowest code
  assign ackVector = {vecBase, intOut ? ackLvl : LVL_W'(NUM_LVL - 1)};
endmodule

// File: rtl/prio_int_ctrl_chk.sv
module prio_int_ctrl_chk
  import pic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               addr,
  input logic               wrEn,
  input logic               rdEn,
  input logic [DATA_W-1:0]  wrData,
  input logic               intAck,
  input logic               intOut,
  input logic [NUM_LVL-1:0] irr,
  input logic [NUM_LVL-1:0] isr,
  input logic [NUM_LVL-1:0] imr,
  input logic               initDone
);
  assert_int_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (|(irr & ~imr)));

  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && wrData[4]) |=> (imr == '0 && isr == '0));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && initDone) |=> (imr == $past(wrData)));

  assert_spec_eoi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addr && initDone && wrData[7:3] == 5'b01100 && !intAck && !rdEn)
      |=> !isr[$past(wrData[LVL_W-1:0])]);

  assert_spurious_ack_R14: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intOut && !wrEn && !rdEn) |=> $stable(isr));
endmodule

bind prio_int_ctrl prio_int_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .intAck(intAck), .intOut(intOut),
  .irr(irrQ), .isr(isrQ), .imr(imrQ), .initDone(initDone)
);

// File: tb/prio_int_ctrl_bench.sv
module prio_int_ctrl_bench;
  logic clk = 0, rstN = 0, addr = 0, wrEn = 0, rdEn = 0, intAck = 0;
  logic [7:0] wrData = 0, irqIn = 0, rdData, ackVector;
  logic intOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_int_ctrl u_prio_int_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .intOut(intOut),
    .intAck(intAck), .ackVector(ackVector)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1; #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); intAck = 1; #1 v = ackVector;
    @(negedge clk); intAck = 0;
  endtask

  task automatic irq(input logic [7:0] v);
    @(negedge clk); irqIn = v;
    @(negedge clk);
  endtask

  task automatic chkInt(input string req, input logic exp);
    #1 check(req, {7'd0, intOut}, {7'd0, exp});
  endtask

  task automatic testReset();
    logic [7:0] v;
    chkInt("R1 intOut", 1'b0);
    rd(1, v); check("R1 mask", v, 8'h00);
    rd(0, v); check("R1 pending", v, 8'h00);
  endtask

  task automatic testBasic();
    logic [7:0] v;
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h01);
    irq(8'h08);
    chkInt("R7 raise", 1'b1);
    rd(0, v); check("R6 edge sets pending", v, 8'h08);
    ack(v); check("R3 vector", v, 8'h23);
    chkInt("R7 drop after ack", 1'b0);
    wr(0, 8'h0B); rd(0, v); check("R11 read in-service", v, 8'h08);
    wr(0, 8'h0A); rd(0, v); check("R6 ack clears pending", v, 8'h00);
    wr(0, 8'h0B);
  endtask

  task automatic testNesting();
    logic [7:0] v;
    irq(8'h28);
    chkInt("R7 lower held off", 1'b0);
    irq(8'h2A);
    chkInt("R7 higher preempts", 1'b1);
    ack(v); check("R7 nested vector", v, 8'h21);
    rd(0, v); check("R7 in-service set", v, 8'h0A);
    wr(0, 8'h20); rd(0, v); check("R8 non-specific", v, 8'h08);
    chkInt("R7 still held", 1'b0);
    wr(0, 8'h63); rd(0, v); check("R8 specific", v, 8'h00);
    chkInt("R7 released", 1'b1);
    ack(v); check("R7 level 5", v, 8'h25);
    wr(0, 8'h20); irq(8'h00);
  endtask

  task automatic testMask();
    logic [7:0] v;
    wr(1, 8'h04); rd(1, v); check("R5 mask read", v, 8'h04);
    irq(8'h04);
    chkInt("R5 masked line", 1'b0);
    wr(0, 8'h0A); rd(0, v); check("R5 pending while masked", v, 8'h04);
    wr(1, 8'h00);
    chkInt("R5 unmasked", 1'b1);
    ack(v); check("R5 vector", v, 8'h22);
    wr(0, 8'h20); irq(8'h00);
  endtask

  task automatic testSpurious();
    logic [7:0] v;
    ack(v); check("R14 spurious vector", v, 8'h27);
    wr(0, 8'h0B); rd(0, v); check("R14 in-service unchanged", v, 8'h00);
  endtask

  task automatic testRotate();
    logic [7:0] v;
    wr(0, 8'hC4);
    irq(8'h44);
    ack(v); check("R9 set lowest", v, 8'h26);
    chkInt("R9 level 2 below 6", 1'b0);
    wr(0, 8'hE6);
    ack(v); check("R9 rotate specific", v, 8'h22);
    wr(0, 8'hA0);
    rd(0, v); check("R9 rotate non-specific retired", v, 8'h00);
    irq(8'h00); irq(8'h0A);
    ack(v); check("R9 order after rotate", v, 8'h23);
    wr(0, 8'h20);
    ack(v); check("R9 wrapped level", v, 8'h21);
    wr(0, 8'h20); wr(0, 8'hC7); irq(8'h00);
  endtask

  task automatic testPoll();
    logic [7:0] v;
    irq(8'h10);
    wr(0, 8'h0C); rd(0, v); check("R12 poll byte", v, 8'h84);
    rd(0, v); check("R12 poll acknowledged", v, 8'h10);
    wr(0, 8'h64);
    wr(0, 8'h0C); rd(0, v); check("R12 empty poll", v, 8'h00);
    irq(8'h00);
  endtask

  task automatic testSpecMask();
    logic [7:0] v;
    irq(8'h40);
    ack(v); check("R13 setup", v, 8'h26);
    irq(8'hC0);
    chkInt("R13 blocked normally", 1'b0);
    wr(1, 8'h40);
    chkInt("R13 mask alone no release", 1'b0);
    wr(0, 8'h68);
    chkInt("R13 special mask releases", 1'b1);
    wr(0, 8'h48);
    chkInt("R13 special mask off", 1'b0);
    wr(1, 8'h00); wr(0, 8'h66);
    ack(v); check("R13 level 7", v, 8'h27);
    rd(0, v); check("R13 in-service", v, 8'h80);
    wr(0, 8'h67); irq(8'h00);
  endtask

  task automatic testAutoEoi();
    logic [7:0] v;
    wr(1, 8'h5A);
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h03);
    rd(1, v); check("R2 restart clears mask", v, 8'h00);
    irq(8'h20);
    ack(v); check("R4 vector", v, 8'h45);
    wr(0, 8'h0B); rd(0, v); check("R4 auto retire", v, 8'h00);
    irq(8'h00);
    wr(0, 8'h80);
    irq(8'h60);
    ack(v); check("R10 first", v, 8'h45);
    ack(v); check("R10 next", v, 8'h46);
    irq(8'h00); irq(8'hA0);
    ack(v); check("R10 rotated order", v, 8'h47);
    ack(v); check("R10 remaining", v, 8'h45);
    wr(0, 8'h00); irq(8'h00);
  endtask

  task automatic testLevel();
    logic [7:0] v;
    wr(0, 8'h18); wr(1, 8'h30); wr(1, 8'h01);
    rd(1, v); check("R4 no mode byte, mask loaded", v, 8'h01);
    wr(1, 8'h00);
    irq(8'h04);
    rd(0, v); check("R6 level follows high", v, 8'h04);
    irq(8'h00);
    rd(0, v); check("R6 level follows low", v, 8'h00);
    irq(8'h04);
    ack(v); check("R3 level vector", v, 8'h32);
    chkInt("R7 same level blocks", 1'b0);
    wr(0, 8'h0B); rd(0, v); check("R4 retire off without mode byte", v, 8'h04);
    wr(0, 8'h20);
    chkInt("R6 level re-asserts", 1'b1);
    irq(8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testBasic();
    testNesting();
    testMask();
    testSpurious();
    testRotate();
    testPoll();
    testSpecMask();
    testAutoEoi();
    testLevel();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule